// File: doc/BRIEF.md
# Framed SPI Command/Address/Data Slave

This block is an SPI peripheral for SPI mode 0. It sits between an external SPI master and a small on-chip byte array. Each transaction lasts as long as chip select is held low. The first byte of a transaction is an opcode, and the opcode decides what the rest of the frame means:

- A read or write opcode is followed by a three-byte location, after which data bytes stream with no limit until chip select rises.
- A status opcode returns a small status byte again and again until chip select rises.
- Any other opcode marks an error and the rest of the frame is ignored.

SCLK, MOSI and chip select are all oversampled in the system clock domain through short synchronizer chains. SCLK must therefore run at no more than a quarter of the system clock rate. Every SCLK edge is turned into a single-cycle strobe. The control module turns those strobes and the received bytes into datapath strobes. The datapath holds the shifters, the location pointer, the byte array and the status state.

Top module: `spiCadSlave`

## Requirements
- R1: `miso` is 0 whenever chip select is high. It is also 0 throughout the opcode phase, the location phase, the write data phase, and any frame that began with an unrecognised opcode.
- R2: Every falling edge of `csN` starts a new frame that expects an opcode. Bits left over from an earlier frame that was cut short have no effect.
- R3: Opcode 0x03 means read and opcode 0x0A means write. Either one is followed by a 24-bit location sent most significant bit first. The low log2(MemDepth) bits of that location select the array entry, and the upper bits are ignored.
- R4: Every byte is shifted most significant bit first. MOSI is sampled on the rising SCLK edge, and MISO changes only after a falling SCLK edge. The first read bit is valid before the first rising edge that follows the location.
- R5: In the data phase the pointer advances by one after each byte. A write stores each complete byte at the current entry, and a read returns consecutive entries.
- R6: The pointer wraps from entry MemDepth-1 back to entry 0, for both reads and writes.
- R7: Opcode 0x05 returns the status byte. The status is sampled again for each byte until chip select rises. Bit 0 is ready, bit 1 is error, bit 2 is busy, and bits 7..3 are 0.
- R8: An unrecognised opcode sets the error flag. The rest of that frame writes nothing to the array.
- R9: The error flag stays set until a status byte carrying it has been loaded for transmission. Status bytes after that one show it clear.
- R10: A byte cut short by chip select rising is discarded, and no entry is written from it.
- R11: A frame that committed at least one write byte sets busy to 1 and ready to 0 for BusyCycles system clocks after chip select rises. A frame with no committed byte leaves both unchanged.
- R12: After reset every array entry is 0x00 and the status byte is 0x01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | SPI serial clock from the master, idle low |
| csN | input | 1 | Active-low chip select that bounds a frame |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master, held at 0 when not transmitting |

## Verification
The bench drives the following patterns, each aimed at a different fault:
- A full-array burst write of an arithmetic byte pattern, read back in one burst, shows that bit order, opcode decode and pointer stepping are right.
- Three-byte reads from every one of the 16 start entries, with junk in the upper location bits, separate a correct wrap at the array end from an off-by-one pointer or a decode that reads the upper bits.
- A write that crosses the array end checks wrapping on the write path.
- Unrecognised opcodes, a frame cut off mid-byte and a frame cut off mid-opcode check that nothing leaks into the array or into the next frame.
- Status reads taken right after a write frame, after the busy window and after an error check each status bit and the point at which the error flag clears.

// File: rtl/spiCadPkg.sv
package spiCadPkg;

  localparam logic [7:0] OpRead   = 8'h03;
  localparam logic [7:0] OpWrite  = 8'h0A;
  localparam logic [7:0] OpStatus = 8'h05;

  typedef enum logic [2:0] {
    PhCmd,
    PhAddr,
    PhRead,
    PhWrite,
    PhStat,
    PhDrop
  } phase_e;

  typedef enum logic [1:0] {
    TxZero,
    TxMem,
    TxStat
  } txSrc_e;

  typedef struct packed {
    logic   rxShift;
    logic   addrByte;
    logic   addrLast;
    logic   commit;
    logic   txLoad;
    logic   txShift;
    txSrc_e txSrc;
    logic   setError;
    logic   startBusy;
    logic   frameClear;
  } strobe_t;

endpackage

// File: rtl/spiCadSync.sv
module spiCadSync #(
  parameter int Stages = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclk,
  input  logic csN,
  input  logic mosi,
  output logic sclkRise,
  output logic sclkFall,
  output logic mosiS,
  output logic csActive
);

  logic [Stages-1:0] sclkPipe;
  logic [Stages-1:0] mosiPipe;
  logic [Stages-1:0] csPipe;
  logic              sclkLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPipe <= '0;
      mosiPipe <= '0;
      csPipe   <= '1;
      sclkLast <= 1'b0;
    end else begin
      sclkPipe <= {sclkPipe[Stages-2:0], sclk};
      mosiPipe <= {mosiPipe[Stages-2:0], mosi};
      csPipe   <= {csPipe[Stages-2:0], csN};
      sclkLast <= sclkPipe[Stages-1];
    end
  end

  assign sclkRise = sclkPipe[Stages-1] & ~sclkLast;
  assign sclkFall = ~sclkPipe[Stages-1] & sclkLast;
  assign mosiS    = mosiPipe[Stages-1];
  assign csActive = ~csPipe[Stages-1];

  initial begin
    a_r4_sync_depth : assert (Stages >= 2)
      else $error("synchronizer needs at least two stages");
  end

  a_r4_edges_exclusive : assert property (@(posedge clk) disable iff (!rstN)
    !(sclkRise && sclkFall));

endmodule

// File: rtl/spiCadCtrl.sv
module spiCadCtrl
  import spiCadPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclkRise,
  input  logic       sclkFall,
  input  logic       csActive,
  input  logic [7:0] rxByte,
  output strobe_t    stb,
  output logic       misoEn
);

  phase_e     phase, phaseNext;
  logic [2:0] bitCnt;
  logic [1:0] addrCnt;
  logic       readOp, readOpNext;
  logic       wroteAny;
  logic       csPrev;
  logic       rise, fall, byteDone;

  always_comb begin
    rise       = sclkRise & csActive;
    fall       = sclkFall & csActive;
    byteDone   = rise && (bitCnt == 3'd7);
    stb        = '0;
    phaseNext  = phase;
    readOpNext = readOp;

    stb.rxShift    = rise;
    stb.frameClear = !csActive;
    stb.startBusy  = csPrev & !csActive & wroteAny;
    stb.txSrc      = TxZero;

    if (byteDone) begin
      case (phase)
        PhCmd: begin
          if (rxByte == OpRead) begin
            phaseNext  = PhAddr;
            readOpNext = 1'b1;
          end else if (rxByte == OpWrite) begin
            phaseNext  = PhAddr;
            readOpNext = 1'b0;
          end else if (rxByte == OpStatus) begin
            phaseNext = PhStat;
          end else begin
            phaseNext    = PhDrop;
            stb.setError = 1'b1;
          end
        end
        PhAddr: begin
          stb.addrByte = 1'b1;
          stb.addrLast = (addrCnt == 2'd2);
          if (addrCnt == 2'd2) phaseNext = readOp ? PhRead : PhWrite;
        end
        PhWrite: stb.commit = 1'b1;
        default: ;
      endcase
    end

    if (fall) begin
      if (bitCnt == 3'd0) begin
        stb.txLoad = 1'b1;
        if (phase == PhRead)      stb.txSrc = TxMem;
        else if (phase == PhStat) stb.txSrc = TxStat;
      end else begin
        stb.txShift = 1'b1;
      end
    end

    misoEn = csActive && (phase == PhRead || phase == PhStat);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PhCmd;
      bitCnt   <= '0;
      addrCnt  <= '0;
      readOp   <= 1'b0;
      wroteAny <= 1'b0;
      csPrev   <= 1'b0;
    end else begin
      csPrev <= csActive;
      if (!csActive) begin
        phase    <= PhCmd;
        bitCnt   <= '0;
        addrCnt  <= '0;
        readOp   <= 1'b0;
        wroteAny <= 1'b0;
      end else begin
        if (rise) bitCnt <= bitCnt + 3'd1;
        phase  <= phaseNext;
        readOp <= readOpNext;
        if (stb.addrByte) addrCnt <= addrCnt + 2'd1;
        if (stb.commit) wroteAny <= 1'b1;
      end
    end
  end

  a_r2_frame_starts_at_cmd : assert property (@(posedge clk) disable iff (!rstN)
    $rose(csActive) |-> (phase == PhCmd && bitCnt == 3'd0 && addrCnt == 2'd0));

  a_r8_drop_never_commits : assert property (@(posedge clk) disable iff (!rstN)
    (phase == PhDrop) |-> !stb.commit);

  a_r8_drop_stays : assert property (@(posedge clk) disable iff (!rstN)
    (phase == PhDrop && csActive) |=> (phase == PhDrop || !csActive));

  a_r1_no_drive_outside_frame : assert property (@(posedge clk) disable iff (!rstN)
    !csActive |-> !misoEn);

endmodule

// File: rtl/spiCadDatapath.sv
module spiCadDatapath
  import spiCadPkg::*;
#(
  parameter int MemDepth   = 16,
  parameter int BusyCycles = 200
) (
  input  logic       clk,
  input  logic       rstN,
  input  strobe_t    stb,
  input  logic       mosiS,
  output logic [7:0] rxByte,
  output logic       txBit
);

  localparam int AddrW = (MemDepth > 1) ? $clog2(MemDepth) : 1;
  localparam int BusyW = $clog2(BusyCycles + 1);
  localparam logic [BusyW-1:0] BusyLoad = BusyW'(BusyCycles);

  logic [7:0]       rxReg;
  logic [15:0]      addrHi;
  logic [23:0]      fullAddr;
  logic [AddrW-1:0] ptr;
  logic [7:0]       mem [MemDepth];
  logic [7:0]       txReg;
  logic             errFlag;
  logic [BusyW-1:0] busyCnt;
  logic             busy;
  logic [7:0]       statusByte;

  assign rxByte     = {rxReg[6:0], mosiS};
  assign fullAddr   = {addrHi, rxByte};
  assign busy       = (busyCnt != '0);
  assign statusByte = {5'b0, busy, errFlag, ~busy};
  assign txBit      = txReg[7];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxReg  <= '0;
      addrHi <= '0;
      ptr    <= '0;
      txReg  <= '0;
    end else if (stb.frameClear) begin
      rxReg  <= '0;
      addrHi <= '0;
      txReg  <= '0;
    end else begin
      if (stb.rxShift) rxReg <= rxByte;
      if (stb.addrByte) addrHi <= fullAddr[15:0];
      if (stb.addrByte && stb.addrLast) ptr <= fullAddr[AddrW-1:0];
      else if (stb.commit) ptr <= ptr + AddrW'(1);
      else if (stb.txLoad && stb.txSrc == TxMem) ptr <= ptr + AddrW'(1);
      if (stb.txLoad) begin
        case (stb.txSrc)
          TxMem:   txReg <= mem[ptr];
          TxStat:  txReg <= statusByte;
          default: txReg <= '0;
        endcase
      end else if (stb.txShift) begin
        txReg <= {txReg[6:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MemDepth; i++) mem[i] <= '0;
    end else if (stb.commit && !stb.frameClear) begin
      mem[ptr] <= rxByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errFlag <= 1'b0;
      busyCnt <= '0;
    end else begin
      if (stb.setError) errFlag <= 1'b1;
      else if (stb.txLoad && stb.txSrc == TxStat && !stb.frameClear) errFlag <= 1'b0;
      if (stb.startBusy) busyCnt <= BusyLoad;
      else if (busy) busyCnt <= busyCnt - BusyW'(1);
    end
  end

  initial begin
    a_r6_depth_pow2 : assert (MemDepth >= 2 && (MemDepth & (MemDepth - 1)) == 0)
      else $error("array depth must be a power of two");
  end

  generate
    for (genvar g = 0; g < MemDepth; g++) begin : gMemGuard
      a_r10_mem_only_on_commit : assert property (@(posedge clk) disable iff (!rstN)
        !$stable(mem[g]) |-> $past(stb.commit));
    end
  endgenerate

  a_r11_busy_only_reloads : assert property (@(posedge clk) disable iff (!rstN)
    (busyCnt > $past(busyCnt)) |-> $past(stb.startBusy));

  a_r4_tx_moves_on_strobe : assert property (@(posedge clk) disable iff (!rstN)
    !$stable(txReg) |-> $past(stb.txLoad || stb.txShift || stb.frameClear));

  a_r9_error_sticky : assert property (@(posedge clk) disable iff (!rstN)
    $fell(errFlag) |-> $past(stb.txLoad && stb.txSrc == TxStat));

endmodule

// File: rtl/spiCadSlave.sv
module spiCadSlave
  import spiCadPkg::*;
#(
  parameter int MemDepth   = 16,
  parameter int BusyCycles = 200,
  parameter int SyncStages = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclk,
  input  logic csN,
  input  logic mosi,
  output logic miso
);

  logic       sclkRise, sclkFall, mosiS, csActive;
  logic [7:0] rxByte;
  logic       txBit, misoEn;
  strobe_t    stb;

  spiCadSync #(.Stages(SyncStages)) uSync (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .mosi(mosi),
    .sclkRise(sclkRise), .sclkFall(sclkFall), .mosiS(mosiS), .csActive(csActive)
  );

  spiCadCtrl uCtrl (
    .clk(clk), .rstN(rstN), .sclkRise(sclkRise), .sclkFall(sclkFall),
    .csActive(csActive), .rxByte(rxByte), .stb(stb), .misoEn(misoEn)
  );

  spiCadDatapath #(.MemDepth(MemDepth), .BusyCycles(BusyCycles)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .mosiS(mosiS), .rxByte(rxByte), .txBit(txBit)
  );

  assign miso = misoEn ? txBit : 1'b0;

  a_r1_miso_quiet : assert property (@(posedge clk) disable iff (!rstN)
    !csActive |-> !miso);

  a_r4_miso_after_fall : assert property (@(posedge clk) disable iff (!rstN)
    (csActive && $past(csActive) && !$stable(miso)) |-> $past(sclkFall));

endmodule

// File: tb/spiCadSlave_test.sv
`timescale 1ns/1ps
module spiCadSlave_test;

  localparam int Depth = 16;
  localparam int Busy  = 200;
  localparam int Half  = 6;
  localparam int Gap   = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b0;
  logic csN = 1'b1;
  logic mosi = 1'b0;
  logic miso;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [7:0] model [Depth];
  logic [7:0] rdBuf [Depth];

  always #4 clk = ~clk;

  spiCadSlave #(.MemDepth(Depth), .BusyCycles(Busy), .SyncStages(2)) uut (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .mosi(mosi), .miso(miso)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp,
                       input string what);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s got=%0h exp=%0h", req, what, got, exp);
    end
  endtask

  task automatic frameBegin();
    csN = 1'b0;
    repeat (Half) @(negedge clk);
  endtask

  task automatic frameEnd();
    repeat (Half) @(negedge clk);
    csN = 1'b1;
    repeat (Gap) @(negedge clk);
  endtask

  task automatic xferBits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int b = 7; b > 7 - n; b--) begin
      mosi = tx[b];
      repeat (Half) @(negedge clk);
      rx[b] = miso;
      sclk = 1'b1;
      repeat (Half) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    xferBits(tx, 8, rx);
  endtask

  task automatic sendHeader(input logic [7:0] op, input logic [23:0] addr, input string req);
    logic [7:0] r;
    xfer(op, r);
    check(req, r, 8'h00, "miso during opcode");
    xfer(addr[23:16], r);
    xfer(addr[15:8], r);
    xfer(addr[7:0], r);
    check(req, r, 8'h00, "miso during location");
  endtask

  task automatic writeBurst(input logic [23:0] addr, input int n, input int seed);
    logic [7:0] r;
    logic [7:0] v;
    int idx;
    frameBegin();
    sendHeader(8'h0A, addr, "R3");
    idx = int'(addr[3:0]);
    for (int k = 0; k < n; k++) begin
      v = 8'((seed + k) * 37 + 5);
      xfer(v, r);
      check("R1", r, 8'h00, "miso during write data");
      model[idx] = v;
      idx = (idx + 1) % Depth;
    end
    frameEnd();
  endtask

  task automatic readBurst(input logic [23:0] addr, input int n);
    frameBegin();
    sendHeader(8'h03, addr, "R3");
    for (int k = 0; k < n; k++) xfer(8'hFF, rdBuf[k]);
    frameEnd();
  endtask

  task automatic statusRead(input int n);
    logic [7:0] r;
    frameBegin();
    xfer(8'h05, r);
    for (int k = 0; k < n; k++) xfer(8'h00, rdBuf[k]);
    frameEnd();
  endtask

  task automatic checkArray(input string req);
    readBurst(24'h000000, Depth);
    for (int k = 0; k < Depth; k++) check(req, rdBuf[k], model[k], $sformatf("entry %0d", k));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog got=timeout exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    for (int k = 0; k < Depth; k++) model[k] = 8'h00;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R12 / R1: reset state
    check("R1", miso, 1'b0, "miso idle after reset");
    statusRead(2);
    check("R12", rdBuf[0], 8'h01, "status after reset");
    check("R7", rdBuf[1], 8'h01, "status repeated");
    checkArray("R12");

    // R5 / R4: full-array burst write then burst read
    writeBurst(24'h000000, Depth, 0);
    statusRead(1);
    check("R11", rdBuf[0], 8'h04, "busy right after write frame");
    repeat (Busy + 100) @(negedge clk);
    statusRead(1);
    check("R11", rdBuf[0], 8'h01, "ready after busy window");
    checkArray("R5");

    // R6 / R3: three-byte reads from every start, junk in upper location bits
    for (int s = 0; s < Depth; s++) begin
      readBurst({8'h5A, 8'h30, 4'h9, 4'(s)}, 3);
      for (int k = 0; k < 3; k++)
        check("R6", rdBuf[k], model[(s + k) % Depth], $sformatf("start %0d byte %0d", s, k));
    end

    // R6: write crossing the array end
    writeBurst(24'hC0FF0E, 4, 50);
    repeat (Busy + 100) @(negedge clk);
    checkArray("R6");

    // R8 / R9: unrecognised opcodes
    frameBegin();
    xfer(8'h77, r);
    xfer(8'h00, r); xfer(8'h00, r); xfer(8'h02, r);
    for (int k = 0; k < 3; k++) begin
      xfer(8'hEE, r);
      check("R8", r, 8'h00, "miso after unknown opcode");
    end
    frameEnd();
    statusRead(2);
    check("R9", rdBuf[0], 8'h03, "error shown once");
    check("R9", rdBuf[1], 8'h01, "error cleared after shifting out");
    checkArray("R8");
    frameBegin();
    xfer(8'h0B, r);
    xfer(8'h00, r); xfer(8'h00, r); xfer(8'h00, r); xfer(8'h99, r);
    frameEnd();
    statusRead(1);
    check("R8", rdBuf[0], 8'h03, "near-write opcode flagged");
    checkArray("R8");

    // R10: byte cut short
    frameBegin();
    sendHeader(8'h0A, 24'h000005, "R3");
    xfer(8'hC3, r);
    xferBits(8'h00, 5, r);
    frameEnd();
    model[5] = 8'hC3;
    repeat (Busy + 100) @(negedge clk);
    checkArray("R10");
    frameBegin();
    sendHeader(8'h0A, 24'h000009, "R3");
    xferBits(8'h00, 3, r);
    frameEnd();
    statusRead(1);
    check("R11", rdBuf[0], 8'h01, "no busy without committed byte");
    check("R10", 32'(model[9]), 32'(model[9]), "model untouched");
    readBurst(24'h000009, 1);
    check("R10", rdBuf[0], model[9], "entry 9 kept");

    // R2: opcode cut short, then a fresh frame
    frameBegin();
    xferBits(8'h0A, 4, r);
    frameEnd();
    statusRead(1);
    check("R2", rdBuf[0], 8'h01, "fresh frame after partial opcode");
    frameBegin();
    xferBits(8'h03, 7, r);
    frameEnd();
    readBurst(24'h00000E, 2);
    check("R2", rdBuf[0], model[14], "read after cut opcode byte 0");
    check("R2", rdBuf[1], model[15], "read after cut opcode byte 1");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule